// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two independent up-counting timer/counters. Each one is built from a low byte and a high byte. A mode register and a control register set the counters up through a small register port. Software uses that port to write the counts and read them back. A counter advances either once per machine cycle or once per falling edge seen on its external count pin. An optional gate pin can qualify running, so a counter can measure how long an external pulse stays high.

Each counter can work as a 13-bit counter, as a 16-bit counter, or as an 8-bit counter that reloads itself from its high byte. Timer 0 can also be split into two 8-bit counters. In that case the second half of timer 0 takes over timer 1's run bit and flag bit. Both overflow flags go out of the block for an interrupt controller, and that controller clears a flag by acknowledging its vector. Every rollover of timer 1 also produces a one-clock pulse, which a serial baud generator can use as its tick.

Top module: `twin_timer`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0x00, both flags are low and `t1_tick` is low.
- R2: Register addresses are: 0 for mode, 1 for control, 2 and 3 for the timer 0 low and high bytes, and 4 and 5 for the timer 1 low and high bytes. In the mode register, bits 3..0 configure timer 0 and bits 7..4 configure timer 1. Each nibble is {GATE, SRC, M1, M0}. In the control register, bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0 and bit 4 is run 0. Control bits 3..0 ignore writes and read as 0.
- R3: Mode 01 is a 16-bit counter made of {high, low}. The flag is set when the count rolls over from FFFFh to 0000h.
- R4: Mode 00 is a 13-bit counter made of {high, low[4:0]}. The flag is set when the count rolls over from all ones. Bits low[7:5] keep the value last written to them.
- R5: Mode 10 counts in the low byte only. When the low byte steps past FFh, it loads the high byte, the flag is set and counting continues. The high byte does not change.
- R6: When timer 0 is in mode 11, its low byte is an 8-bit counter that uses timer 0's source, run bit and gate, and it sets flag 0. Its high byte counts machine cycles under run 1 and sets flag 1.
- R7: When timer 1 is in mode 11, it holds its count.
- R8: A counter runs only while its run bit is 1 and either GATE is 0 or its gate pin is high.
- R9: With SRC=1, the count pin is sampled once per machine cycle. After a high sample and then a low sample, the count advances in the next machine cycle. The count can therefore advance at most once every two machine cycles.
- R10: A pulse on `vec_ack[i]` clears flag i. If an overflow happens in the same cycle, the overflow wins and sets the flag. A control write sets both flags to the written values and overrides both the overflow and the acknowledge.
- R11: When a register write and an increment of the same byte land in the same cycle, the written value is kept.
- R12: Every timer 1 rollover raises `t1_tick` for exactly one clock, starting the clock after the rollover edge. This holds in modes 00, 01 and 10. While timer 0 is split, timer 1 ignores run 1, still produces `t1_tick`, and does not touch flag 1.
- R13: When `mc_en` is low, no counter changes and the count pins are not sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle enable, one clock per machine cycle |
| ext_cnt | input | 2 | External count pins, bit i belongs to timer i |
| gate_in | input | 2 | Gate pins, bit i qualifies timer i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| vec_ack | input | 2 | Vector acknowledge, bit i clears flag i |
| ovf_flag | output | 2 | Overflow flags, bit i for timer i |
| t1_tick | output | 1 | One-clock pulse on each timer 1 rollover |

## Verification
The bench targets the boundaries of each counting mode:
- **13-bit rollover.** It checks that bits 7..5 of the low byte survive the rollover. A design that carried through the full byte would read E0h as 00h.
- **Auto-reload.** It checks that the reload value comes from the high byte. A design that wrapped the low byte to 00h, or that also advanced the high byte, would show the wrong count after the reload.
- **Edge counting.** It drives fast pin toggling and checks that the count advances only once per high-then-low pair, and only in the machine cycle after the low sample. A level counter or a same-cycle edge detector would end on a different count.
- **Split mode.** It checks that run 1 and flag 1 are routed to timer 0's high byte. It also checks that timer 1 is frozen in its own mode 11, and that the baud tick still fires from timer 1 while its flag is left untouched.
- **Same-cycle collisions.** It checks that a write wins over an increment in the same cycle, and that an overflow wins over an acknowledge in the same cycle. Getting either priority wrong leaves a visibly wrong byte or flag.

// File: rtl/twin_timer_pkg.sv
`timescale 1ns/1ps
package twin_timer_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NUM_TMR = 2;
    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] ADR_MODE = 3'd0;
    localparam logic [REG_AW-1:0] ADR_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] ADR_LO0  = 3'd2;
    localparam logic [REG_AW-1:0] ADR_HI0  = 3'd3;
    localparam logic [REG_AW-1:0] ADR_LO1  = 3'd4;
    localparam logic [REG_AW-1:0] ADR_HI1  = 3'd5;

    typedef enum logic [1:0] {
        MODE_13    = 2'b00,
        MODE_16    = 2'b01,
        MODE_RLD   = 2'b10,
        MODE_SPLIT = 2'b11
    } cnt_mode_e;

    // One configuration nibble, MSB first: gate, source, mode
    typedef struct packed {
        logic      gate;
        logic      ext_src;
        cnt_mode_e mode;
    } cfg_nib_t;

    // Run qualification shared by every counting path
    function automatic logic run_ok(input logic run_bit, input logic gate, input logic pin);
        return run_bit & (~gate | pin);
    endfunction

    // Address of a timer's low byte
    function automatic logic [REG_AW-1:0] lo_addr(input int unsigned idx);
        return (idx == 0) ? ADR_LO0 : ADR_LO1;
    endfunction

    function automatic logic [REG_AW-1:0] hi_addr(input int unsigned idx);
        return (idx == 0) ? ADR_HI0 : ADR_HI1;
    endfunction

endpackage

// File: rtl/tt_pin_sampler.sv
`timescale 1ns/1ps
module tt_pin_sampler (
    input  logic clk,
    input  logic rst,
    input  logic mc_en,
    input  logic pin,
    output logic fall
);
    logic smp_now;
    logic smp_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_now <= 1'b0;
            smp_old <= 1'b0;
        end else if (mc_en) begin
            smp_now <= pin;
            smp_old <= smp_now;
        end
    end

    // High sample followed by low sample: count in this machine cycle
    assign fall = mc_en & smp_old & ~smp_now;

    // R9
    fall_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/tt_count_unit.sv
`timescale 1ns/1ps
module tt_count_unit
    import twin_timer_pkg::*;
#(
    parameter int unsigned LOW_W    = 5,
    parameter bit          SPLIT_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_mode_e         mode,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf_a,
    output logic              ovf_b
);
    localparam int unsigned W13 = BYTE_W + LOW_W;
    localparam int unsigned W16 = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_nx, hi_nx;
    logic [W13-1:0]    cat13, sum13;
    logic [W16-1:0]    cat16, sum16;

    assign cat13 = {hi, lo[LOW_W-1:0]};
    assign sum13 = cat13 + {{(W13-1){1'b0}}, 1'b1};
    assign cat16 = {hi, lo};
    assign sum16 = cat16 + {{(W16-1){1'b0}}, 1'b1};

    always_comb begin
        lo_nx = lo;
        hi_nx = hi;
        ovf_a = 1'b0;
        ovf_b = 1'b0;
        unique case (mode)
            MODE_13: if (tick_a) begin
                hi_nx            = sum13[W13-1:LOW_W];
                lo_nx[LOW_W-1:0] = sum13[LOW_W-1:0];
                ovf_a            = &cat13;
            end
            MODE_16: if (tick_a) begin
                {hi_nx, lo_nx} = sum16;
                ovf_a          = &cat16;
            end
            MODE_RLD: if (tick_a) begin
                if (&lo) begin
                    lo_nx = hi;
                    ovf_a = 1'b1;
                end else begin
                    lo_nx = lo + {{(BYTE_W-1){1'b0}}, 1'b1};
                end
            end
            MODE_SPLIT: if (SPLIT_OK) begin
                if (tick_a) begin
                    lo_nx = lo + {{(BYTE_W-1){1'b0}}, 1'b1};
                    ovf_a = &lo;
                end
                if (tick_b) begin
                    hi_nx = hi + {{(BYTE_W-1){1'b0}}, 1'b1};
                    ovf_b = &hi;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= wr_lo ? wdata : lo_nx;
            hi <= wr_hi ? wdata : hi_nx;
        end
    end

    // R4
    m13_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_13 && !wr_lo) |=> lo[BYTE_W-1:LOW_W] == $past(lo[BYTE_W-1:LOW_W]));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RLD && tick_a && (&lo) && !wr_lo && !wr_hi) |=> (lo == hi && ovf_a == 1'b0) || lo == hi);

    generate
        if (!SPLIT_OK) begin : g_hold
            // R7
            split_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (mode == MODE_SPLIT && !wr_lo && !wr_hi) |=> $stable(lo) && $stable(hi));
        end
    endgenerate

endmodule

// File: rtl/twin_timer.sv
`timescale 1ns/1ps
module twin_timer
    import twin_timer_pkg::*;
#(
    parameter int unsigned LOW_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mc_en,
    input  logic [1:0]        ext_cnt,
    input  logic [1:0]        gate_in,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [1:0]        vec_ack,
    output logic [1:0]        ovf_flag,
    output logic              t1_tick
);
    localparam int unsigned NIB_W = BYTE_W / 2;

    logic [BYTE_W-1:0]  mode_q;
    logic [NUM_TMR-1:0] run_q;
    logic [NUM_TMR-1:0] flag_q;
    logic               tick_q;

    cfg_nib_t           cfg   [NUM_TMR];
    logic [NUM_TMR-1:0] fall, src, qual, tick_a, tick_b, wr_lo, wr_hi, ovf_a, ovf_b;
    logic [BYTE_W-1:0]  lo [NUM_TMR];
    logic [BYTE_W-1:0]  hi [NUM_TMR];
    logic               split0, ctrl_wr;
    logic [NUM_TMR-1:0] set_flag;

    assign ctrl_wr = reg_we && reg_addr == ADR_CTRL;
    assign split0  = cfg[0].mode == MODE_SPLIT;

    generate
        for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
            assign cfg[i]   = cfg_nib_t'(mode_q[NIB_W*i +: NIB_W]);
            assign wr_lo[i] = reg_we && reg_addr == lo_addr(i);
            assign wr_hi[i] = reg_we && reg_addr == hi_addr(i);
            assign src[i]   = cfg[i].ext_src ? fall[i] : mc_en;

            tt_pin_sampler u_smp (
                .clk   (clk),
                .rst   (rst),
                .mc_en (mc_en),
                .pin   (ext_cnt[i]),
                .fall  (fall[i])
            );

            tt_count_unit #(
                .LOW_W    (LOW_W),
                .SPLIT_OK (i == 0)
            ) u_cnt (
                .clk    (clk),
                .rst    (rst),
                .mode   (cfg[i].mode),
                .tick_a (tick_a[i]),
                .tick_b (tick_b[i]),
                .wr_lo  (wr_lo[i]),
                .wr_hi  (wr_hi[i]),
                .wdata  (reg_wdata),
                .lo     (lo[i]),
                .hi     (hi[i]),
                .ovf_a  (ovf_a[i]),
                .ovf_b  (ovf_b[i])
            );
        end
    endgenerate

    // Timer 1 loses its run bit to timer 0's upper half while timer 0 is split
    assign qual[0]   = run_ok(run_q[0], cfg[0].gate, gate_in[0]);
    assign qual[1]   = run_ok(split0 ? 1'b1 : run_q[1], cfg[1].gate, gate_in[1]);
    assign tick_a    = qual & src;
    assign tick_b[0] = split0 & run_q[1] & mc_en;
    assign tick_b[1] = 1'b0;

    assign set_flag[0] = ovf_a[0];
    assign set_flag[1] = split0 ? ovf_b[0] : ovf_a[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= ovf_a[1];
            if (reg_we && reg_addr == ADR_MODE) mode_q <= reg_wdata;
            if (ctrl_wr) begin
                run_q  <= {reg_wdata[6], reg_wdata[4]};
                flag_q <= {reg_wdata[7], reg_wdata[5]};
            end else begin
                for (int i = 0; i < NUM_TMR; i++) begin
                    if (set_flag[i])     flag_q[i] <= 1'b1;
                    else if (vec_ack[i]) flag_q[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_MODE: reg_rdata = mode_q;
            ADR_CTRL: reg_rdata = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
            ADR_LO0:  reg_rdata = lo[0];
            ADR_HI0:  reg_rdata = hi[0];
            ADR_LO1:  reg_rdata = lo[1];
            ADR_HI1:  reg_rdata = hi[1];
            default:  reg_rdata = '0;
        endcase
    end

    assign ovf_flag = flag_q;
    assign t1_tick  = tick_q;

    // R10
    flag0_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_a[0] && !ctrl_wr) |=> ovf_flag[0]);

    // R10
    flag0_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_ack[0] && !set_flag[0] && !ctrl_wr) |=> !ovf_flag[0]);

    // R12
    split_flag1_chk: assert property (@(posedge clk) disable iff (rst)
        (split0 && ovf_a[1] && !ovf_b[0] && !ctrl_wr && !ovf_flag[1]) |=> !ovf_flag[1]);

    // R13
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mc_en && !reg_we) |=> $stable(lo[0]) && $stable(hi[0]) && $stable(lo[1]) && $stable(hi[1]));

endmodule

// File: tb/twin_timer_test.sv
`timescale 1ns/1ps
module twin_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mc_en = 1'b0;
    logic [1:0] ext_cnt = 2'b00;
    logic [1:0] gate_in = 2'b00;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] vec_ack = 2'b00;
    logic [1:0] ovf_flag;
    logic       t1_tick;

    localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_LO0 = 3'd2,
                           A_HI0 = 3'd3, A_LO1 = 3'd4, A_HI1 = 3'd5;

    always #2.5 clk = ~clk;

    twin_timer uut (
        .clk       (clk),
        .rst       (rst),
        .mc_en     (mc_en),
        .ext_cnt   (ext_cnt),
        .gate_in   (gate_in),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .vec_ack   (vec_ack),
        .ovf_flag  (ovf_flag),
        .t1_tick   (t1_tick)
    );

    typedef struct {
        string       req;
        logic [15:0] exp;
        logic [15:0] got;
    } sb_item_t;

    sb_item_t sb[$];
    int n_chk = 0;
    int n_err = 0;
    int pulses = 0;
    bit done = 1'b0;

    // Monitor: drain the scoreboard and compare
    always @(posedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.got !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual %0h expected %0h", it.req, it.got, it.exp);
            end
        end
    end

    task automatic push(input string req, input logic [15:0] got, input logic [15:0] exp);
        sb_item_t it;
        it.req = req;
        it.got = got;
        it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        push(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        mc_en = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (t1_tick) pulses++;
        end
        mc_en = 1'b0;
    endtask

    task automatic pins(input logic [15:0] pat, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            mc_en = 1'b1;
            ext_cnt[0] = pat[i];
        end
        @(negedge clk);
        mc_en = 1'b0;
        ext_cnt[0] = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) chk_reg("R1", a[2:0], 8'h00);
        push("R1 flags", {14'd0, ovf_flag}, 16'd0);
        push("R1 tick", {15'd0, t1_tick}, 16'd0);

        // R2 reserved control bits, flag position
        wr(A_CTRL, 8'h2F);
        chk_reg("R2 ctrl", A_CTRL, 8'h20);
        push("R2 flag0", {14'd0, ovf_flag}, 16'd1);
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'hA5);
        chk_reg("R2 mode", A_MODE, 8'hA5);

        // R3 16-bit rollover
        wr(A_MODE, 8'h01); wr(A_LO0, 8'hFE); wr(A_HI0, 8'hFF); wr(A_CTRL, 8'h10);
        tick(1);
        chk_reg("R3 lo", A_LO0, 8'hFF);
        push("R3 no flag", {14'd0, ovf_flag}, 16'd0);
        tick(1);
        chk_reg("R3 lo wrap", A_LO0, 8'h00);
        chk_reg("R3 hi wrap", A_HI0, 8'h00);
        push("R3 flag", {14'd0, ovf_flag}, 16'd1);

        // R10 acknowledge
        @(negedge clk); vec_ack = 2'b01;
        @(negedge clk); vec_ack = 2'b00;
        push("R10 ack", {14'd0, ovf_flag}, 16'd0);
        // R10 overflow beats acknowledge
        wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
        @(negedge clk); mc_en = 1'b1; vec_ack = 2'b01;
        @(negedge clk); mc_en = 1'b0; vec_ack = 2'b00;
        push("R10 set wins", {14'd0, ovf_flag}, 16'd1);

        // R4 13-bit mode
        wr(A_CTRL, 8'h00); wr(A_MODE, 8'h00); wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
        wr(A_CTRL, 8'h10);
        tick(1);
        chk_reg("R4 lo", A_LO0, 8'hE0);
        chk_reg("R4 hi", A_HI0, 8'h00);
        push("R4 flag", {14'd0, ovf_flag}, 16'd1);
        tick(1);
        chk_reg("R4 next", A_LO0, 8'hE1);

        // R5 auto-reload
        wr(A_CTRL, 8'h00); wr(A_MODE, 8'h02); wr(A_LO0, 8'hFE); wr(A_HI0, 8'h80);
        wr(A_CTRL, 8'h10);
        tick(1);
        push("R5 pre", {14'd0, ovf_flag}, 16'd0);
        tick(1);
        chk_reg("R5 reload", A_LO0, 8'h80);
        push("R5 flag", {14'd0, ovf_flag}, 16'd1);
        tick(1);
        chk_reg("R5 cont", A_LO0, 8'h81);
        chk_reg("R5 hi", A_HI0, 8'h80);

        // R8 gating
        wr(A_CTRL, 8'h00); wr(A_MODE, 8'h09); wr(A_LO0, 8'h00); wr(A_HI0, 8'h00);
        wr(A_CTRL, 8'h10);
        tick(3);
        chk_reg("R8 gate low", A_LO0, 8'h00);
        gate_in[0] = 1'b1;
        tick(3);
        chk_reg("R8 gate high", A_LO0, 8'h03);
        wr(A_CTRL, 8'h00);
        tick(2);
        chk_reg("R8 run off", A_LO0, 8'h03);
        gate_in[0] = 1'b0;

        // R9 edge counting
        wr(A_MODE, 8'h05); wr(A_LO0, 8'h00); wr(A_HI0, 8'h00); wr(A_CTRL, 8'h10);
        pins(16'b00011, 5);
        chk_reg("R9 one edge", A_LO0, 8'h01);
        pins(16'b0001010101, 10);
        chk_reg("R9 fast toggle", A_LO0, 8'h05);

        // R13 no sampling without mc_en
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ext_cnt[0] = ~ext_cnt[0];
        end
        pins(16'b000, 3);
        chk_reg("R13 hold", A_LO0, 8'h05);

        // R11 write beats increment
        wr(A_CTRL, 8'h00); wr(A_MODE, 8'h01); wr(A_LO0, 8'h10); wr(A_CTRL, 8'h10);
        @(negedge clk);
        mc_en = 1'b1; reg_we = 1'b1; reg_addr = A_LO0; reg_wdata = 8'h55;
        @(negedge clk);
        mc_en = 1'b0; reg_we = 1'b0;
        chk_reg("R11 write", A_LO0, 8'h55);
        tick(1);
        chk_reg("R11 after", A_LO0, 8'h56);

        // R6 / R7 split mode
        wr(A_CTRL, 8'h00); wr(A_MODE, 8'h33);
        wr(A_LO1, 8'h12); wr(A_HI1, 8'h34); wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFE);
        wr(A_CTRL, 8'h50);
        pulses = 0;
        tick(1);
        chk_reg("R6 lo0", A_LO0, 8'h00);
        chk_reg("R6 hi0", A_HI0, 8'hFF);
        chk_reg("R6 ctrl", A_CTRL, 8'h70);
        tick(1);
        chk_reg("R6 hi0 wrap", A_HI0, 8'h00);
        chk_reg("R6 ctrl2", A_CTRL, 8'hF0);
        chk_reg("R7 lo1", A_LO1, 8'h12);
        chk_reg("R7 hi1", A_HI1, 8'h34);
        push("R12 no tick", pulses[15:0], 16'd0);
        wr(A_CTRL, 8'h10);
        tick(2);
        chk_reg("R6 lo0 runs", A_LO0, 8'h03);
        chk_reg("R6 hi0 stops", A_HI0, 8'h00);

        // R12 tick while timer 0 split, flag 1 untouched
        wr(A_MODE, 8'h23); wr(A_LO1, 8'hFF); wr(A_HI1, 8'hF0); wr(A_CTRL, 8'h10);
        pulses = 0;
        tick(1);
        chk_reg("R12 split reload", A_LO1, 8'hF0);
        push("R12 split tick", pulses[15:0], 16'd1);
        push("R12 split flag1", {15'd0, ovf_flag[1]}, 16'd0);

        // R12 tick in auto-reload
        wr(A_CTRL, 8'h00); wr(A_MODE, 8'h20); wr(A_LO1, 8'hFF); wr(A_HI1, 8'hFE);
        wr(A_CTRL, 8'h40);
        pulses = 0;
        tick(1);
        push("R12 tick", pulses[15:0], 16'd1);
        push("R12 flag1", {15'd0, ovf_flag[1]}, 16'd1);
        pulses = 0;
        tick(4);
        push("R12 rate", pulses[15:0], 16'd2);
        @(negedge clk);
        push("R12 width", {15'd0, t1_tick}, 16'd0);
        chk_reg("R12 lo1", A_LO1, 8'hFE);

        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule